// File: doc/BRIEF.md
# Flow-Gated Asynchronous Serial Transmitter

This block turns bytes from a show-ahead transmit queue into asynchronous serial frames. Each frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a high stop period. Bit timing comes from a one-cycle enable pulse at sixteen times the baud rate, so every bit lasts sixteen pulses. When the queue still holds data at the end of a frame, the next frame follows with no idle gap.

With automatic clear-to-send gating enabled, the active-low `cts_n` input decides whether a new frame may begin. While the line is idle, the input is looked at on every baud pulse. While a frame is in flight, it is sampled once, eight pulses before the end of the final stop period. A frame that has started always completes. A frame that would follow it is held back when `cts_n` was high at that sample.

A break control forces the line low for as long as it is held. A loopback control keeps the external pin at the idle level and sends the line to a local receiver output. The queue, the baud divisor and the host registers are outside this block.

Top module: `uart_tx_flow`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `tx_out` and `loop_rx` are 1, and `busy`, `fifo_rd` and `shift_empty` are 0.
- R2: A frame starts in the cycle after a `fifo_rd` pulse. The line is 0 for 16 `tick16` pulses (the start bit), then carries each data bit for 16 pulses, least significant bit first.
- R3: `char_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `fifo_data` above that count are not sent.
- R4: With `parity_en`=1, one parity bit of 16 pulses follows the data. With `parity_odd`=0 the parity bit makes the count of ones over the data and parity bits even; with `parity_odd`=1 it makes that count odd. With `parity_en`=0 no parity bit is sent.
- R5: The stop period is high. It lasts 16 pulses when `stop_long`=0, 24 pulses when `stop_long`=1 and `char_len`=00, and 32 pulses when `stop_long`=1 with any other length.
- R6: `fifo_rd` is a one-cycle pulse. It is asserted only in a cycle where `tick16`=1 and `fifo_empty`=0, and `fifo_data` is taken in that cycle. When data is waiting and sending is allowed, the next frame begins on the pulse that ends the previous stop period, with no idle gap.
- R7: With `afe`=0, `cts_n` has no effect: queued data is sent while `cts_n`=1.
- R8: With `afe`=1 and the line idle, no frame starts while `cts_n`=1. A frame starts on the first `tick16` pulse that sees `cts_n`=0 with data waiting.
- R9: With `afe`=1 during a frame, `cts_n` is sampled on the pulse that leaves 8 pulses of the stop period to run. If it is 1 there, the frame in flight completes and no frame follows back to back. If it is 0 there, the next frame follows even if `cts_n` rises afterwards.
- R10: While `break_en`=1, the serial line is 0 whatever the frame state. Frame timing continues underneath.
- R11: With `loopback`=1, `tx_out` is held at 1 and `loop_rx` carries the serial line, including break. With `loopback`=0, `loop_rx` is 1 and `tx_out` carries the line.
- R12: `busy` is 1 from the cycle after a `fifo_rd` until the cycle after the final stop pulse of a frame that has no successor. `shift_empty` pulses for one cycle on that final stop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the baud rate |
| fifo_empty | input | 1 | Transmit queue holds no data |
| fifo_data | input | 8 | Head of the transmit queue (show-ahead) |
| fifo_rd | output | 1 | Pops the queue head |
| char_len | input | 2 | Data bit count select |
| parity_en | input | 1 | Parity bit enable |
| parity_odd | input | 1 | Odd parity when 1, even when 0 |
| stop_long | input | 1 | Longer stop period select |
| afe | input | 1 | Automatic clear-to-send gating enable |
| cts_n | input | 1 | Clear to send, active low |
| break_en | input | 1 | Force the line low |
| loopback | input | 1 | Route the line to `loop_rx`, idle the pin |
| tx_out | output | 1 | Serial output pin |
| loop_rx | output | 1 | Line fed to the local receiver |
| busy | output | 1 | A frame is in progress |
| shift_empty | output | 1 | Pulse when the shifter runs out of frames |

## Verification
The bench aims at the clear-to-send sample point. `cts_n` is raised once before and once after the pulse that leaves eight stop pulses to run. A design that sampled at the wrong moment would either hold back a frame that should follow or send one that should wait. The bench also covers the 24-pulse stop period, which is used only for 5-bit characters; a design that applied it to other lengths, or used 32 pulses there, would end the frame at the wrong time. It drives back-to-back frames at a baud pulse on every clock, where an extra idle pulse or a double queue read would show up at once. Break is asserted during loopback, which exposes a mux that lets break reach the pin or keeps it away from the receiver path.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers for the flow-gated serial transmitter.
// Assumes a character length code of two bits, 00 meaning five data bits.
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Number of data bits for a length code
    function automatic logic [3:0] data_bits(input logic [1:0] len_code);
        return 4'd5 + {2'b00, len_code};
    endfunction

endpackage

// File: rtl/tx_frame_fsm.sv
// Frame sequencer: start, data (LSB first), optional parity, stop.
// Counts baud pulses within each phase. Assumes format inputs stay
// stable while a frame is in flight and that load only arrives on a pulse.
module tx_frame_fsm
    import uart_tx_pkg::*;
#(
    parameter int OS = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          load,
    input  logic [DW-1:0] fifo_data,
    input  logic [1:0]    char_len,
    input  logic          parity_en,
    input  logic          parity_odd,
    input  logic          stop_long,
    output logic          ser_bit,
    output logic          busy,
    output logic          stop_end,
    output logic          cts_sample
);
    localparam int CNT_W = $clog2(2 * OS + 1);
    localparam int IDX_W = $clog2(DW);

    tx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DW-1:0]     shreg;
    logic              par_bit;
    logic [CNT_W-1:0]  stop_ticks;
    logic              phase_last;
    logic [IDX_W-1:0]  last_idx;
    logic [DW-1:0]     mask;

    // Stop period length in baud pulses
    always_comb begin
        if (!stop_long)
            stop_ticks = CNT_W'(OS);
        else if (char_len == 2'b00)
            stop_ticks = CNT_W'(OS + OS / 2);
        else
            stop_ticks = CNT_W'(2 * OS);
    end

    // Mask of the data bits that belong to the character
    always_comb begin
        for (int i = 0; i < DW; i++)
            mask[i] = (i < int'(data_bits(char_len)));
    end

    assign last_idx   = IDX_W'(data_bits(char_len) - 4'd1);
    assign phase_last = (state == ST_STOP) ? (cnt == stop_ticks - CNT_W'(1))
                                           : (cnt == CNT_W'(OS - 1));
    assign stop_end   = tick16 && (state == ST_STOP) && phase_last;
    assign cts_sample = tick16 && (state == ST_STOP)
                        && (cnt == stop_ticks - CNT_W'(OS / 2 + 1));
    assign busy       = (state != ST_IDLE);

    // Phase sequencing, pulse counting and data shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else if (load) begin
            state   <= ST_START;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= fifo_data;
            par_bit <= parity_odd ^ (^(fifo_data & mask));
        end else if (tick16 && state != ST_IDLE) begin
            if (!phase_last) begin
                cnt <= cnt + CNT_W'(1);
            end else begin
                cnt <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (bit_idx == last_idx)
                            state <= parity_en ? ST_PARITY : ST_STOP;
                        else
                            bit_idx <= bit_idx + IDX_W'(1);
                    end
                    ST_PARITY: state <= ST_STOP;
                    default:   state <= ST_IDLE;
                endcase
            end
        end
    end

    // Line level for the current phase
    always_comb begin
        case (state)
            ST_START:  ser_bit = 1'b0;
            ST_DATA:   ser_bit = shreg[0];
            ST_PARITY: ser_bit = par_bit;
            default:   ser_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/tx_cts_gate.sv
// Start permission: live clear-to-send check while idle, and a value
// latched at the stop-period sample point for back-to-back frames.
// Assumes the sequencer raises stop_end only on a baud pulse.
module tx_cts_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic fifo_empty,
    input  logic afe,
    input  logic cts_n,
    input  logic busy,
    input  logic stop_end,
    input  logic cts_sample,
    output logic fifo_rd,
    output logic shift_empty
);
    logic live_ok;
    logic held_ok;

    assign live_ok = !afe || !cts_n;

    // Capture permission at the sample point inside the final stop period
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_ok <= 1'b0;
        else if (cts_sample)
            held_ok <= live_ok;
    end

    assign fifo_rd     = tick16 && !fifo_empty
                         && ((!busy && live_ok) || (stop_end && held_ok));
    assign shift_empty = stop_end && !fifo_rd;

endmodule

// File: rtl/tx_line_mux.sv
// Output steering: break override, then loopback routing.
// Purely combinational; assumes ser_bit comes from registered state.
module tx_line_mux (
    input  logic ser_bit,
    input  logic break_en,
    input  logic loopback,
    output logic tx_out,
    output logic loop_rx
);
    logic line;

    assign line    = break_en ? 1'b0 : ser_bit;
    assign tx_out  = loopback ? 1'b1 : line;
    assign loop_rx = loopback ? line : 1'b1;

endmodule

// File: rtl/uart_tx_flow.sv
// Flow-gated asynchronous serial transmitter top level.
// Pulls bytes from a show-ahead queue, frames them on 16x baud pulses,
// gates frame starts on clear-to-send when enabled, and steers the line
// through break and loopback controls.
module uart_tx_flow #(
    parameter int OS = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    output logic          fifo_rd,
    input  logic [1:0]    char_len,
    input  logic          parity_en,
    input  logic          parity_odd,
    input  logic          stop_long,
    input  logic          afe,
    input  logic          cts_n,
    input  logic          break_en,
    input  logic          loopback,
    output logic          tx_out,
    output logic          loop_rx,
    output logic          busy,
    output logic          shift_empty
);
    logic ser_bit;
    logic stop_end;
    logic cts_sample;

    tx_frame_fsm #(.OS(OS), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16     (tick16),
        .load       (fifo_rd),
        .fifo_data  (fifo_data),
        .char_len   (char_len),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .stop_long  (stop_long),
        .ser_bit    (ser_bit),
        .busy       (busy),
        .stop_end   (stop_end),
        .cts_sample (cts_sample)
    );

    tx_cts_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick16      (tick16),
        .fifo_empty  (fifo_empty),
        .afe         (afe),
        .cts_n       (cts_n),
        .busy        (busy),
        .stop_end    (stop_end),
        .cts_sample  (cts_sample),
        .fifo_rd     (fifo_rd),
        .shift_empty (shift_empty)
    );

    tx_line_mux u_mux (
        .ser_bit  (ser_bit),
        .break_en (break_en),
        .loopback (loopback),
        .tx_out   (tx_out),
        .loop_rx  (loop_rx)
    );

endmodule

// File: rtl/uart_tx_flow_chk.sv
// Port-level properties of the transmitter, bound to every instance.
module uart_tx_flow_chk (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic fifo_empty,
    input logic fifo_rd,
    input logic afe,
    input logic cts_n,
    input logic break_en,
    input logic loopback,
    input logic tx_out,
    input logic loop_rx,
    input logic busy,
    input logic shift_empty
);
    AST_RD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty); // R6
    AST_RD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> tick16); // R6
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> !fifo_rd); // R6
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> (!tx_out || break_en || loopback)); // R2
    AST_IDLE_CTS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (afe && cts_n && !busy) |-> !fifo_rd); // R8
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (break_en && !loopback) |-> !tx_out); // R10
    AST_LOOP_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        loopback |-> tx_out); // R11
    AST_NOLOOP_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !loopback |-> loop_rx); // R11
    AST_EMPTY_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |=> !busy); // R12
    AST_RD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> busy); // R12
endmodule

bind uart_tx_flow uart_tx_flow_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick16      (tick16),
    .fifo_empty  (fifo_empty),
    .fifo_rd     (fifo_rd),
    .afe         (afe),
    .cts_n       (cts_n),
    .break_en    (break_en),
    .loopback    (loopback),
    .tx_out      (tx_out),
    .loop_rx     (loop_rx),
    .busy        (busy),
    .shift_empty (shift_empty)
);

// File: tb/uart_tx_flow_test.sv
// Bench: a behavioural model keeps a queue of line levels, one per baud
// pulse, and is compared with the design on every falling clock edge.
module uart_tx_flow_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       fifo_empty = 1'b1;
    logic [7:0] fifo_data = 8'h00;
    logic       fifo_rd;
    logic [1:0] char_len = 2'b11;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       stop_long = 1'b0;
    logic       afe = 1'b0;
    logic       cts_n = 1'b0;
    logic       break_en = 1'b0;
    logic       loopback = 1'b0;
    logic       tx_out, loop_rx, busy, shift_empty;

    always #4 clk = ~clk;

    uart_tx_flow uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_rd(fifo_rd), .char_len(char_len),
        .parity_en(parity_en), .parity_odd(parity_odd), .stop_long(stop_long),
        .afe(afe), .cts_n(cts_n), .break_en(break_en), .loopback(loopback),
        .tx_out(tx_out), .loop_rx(loop_rx), .busy(busy), .shift_empty(shift_empty)
    );

    int      vectors = 0;
    int      miscompares = 0;
    int      cyc = 0;
    int      tick_div = 3;
    string   req = "R1";
    bit      model_on = 1'b0;
    bit [7:0] fq[$];
    bit      lvl_q[$];
    bit      held = 1'b0;
    bit      live, idle, rd_e, se_e, line_e;

    task automatic check(string r, string nm, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", r, nm, act, exp, $time);
        end
    endtask

    function automatic void refresh();
        fifo_empty = (fq.size() == 0);
        fifo_data  = (fq.size() != 0) ? fq[0] : 8'h00;
    endfunction

    // Push one frame of line levels, one entry per baud pulse
    function automatic void build(bit [7:0] d);
        int n = 5 + int'(char_len);
        bit p = parity_odd;
        int sl;
        for (int k = 0; k < 16; k++) lvl_q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            p ^= d[i];
            for (int k = 0; k < 16; k++) lvl_q.push_back(d[i]);
        end
        if (parity_en)
            for (int k = 0; k < 16; k++) lvl_q.push_back(p);
        sl = !stop_long ? 16 : (char_len == 2'b00 ? 24 : 32);
        for (int k = 0; k < sl; k++) lvl_q.push_back(1'b1);
    endfunction

    // Baud pulse generator and queue head presentation
    always @(posedge clk) begin
        #1;
        cyc++;
        tick16 = ((cyc % tick_div) == 0);
        refresh();
    end

    // Reference model and per-cycle comparison
    always @(negedge clk) begin
        if (model_on) begin
            live   = !afe || !cts_n;
            idle   = (lvl_q.size() == 0);
            rd_e   = tick16 && (fq.size() != 0) && ((idle && live) || (lvl_q.size() == 1 && held));
            se_e   = tick16 && (lvl_q.size() == 1) && !rd_e;
            line_e = break_en ? 1'b0 : (idle ? 1'b1 : lvl_q[0]);
            check(req, "tx_out", tx_out, loopback ? 1'b1 : line_e);
            check(req, "loop_rx", loop_rx, loopback ? line_e : 1'b1);
            check(req, "busy", busy, !idle);
            check(req, "fifo_rd", fifo_rd, rd_e);
            check(req, "shift_empty", shift_empty, se_e);
            if (tick16) begin
                if (!idle) begin
                    void'(lvl_q.pop_front());
                    if (lvl_q.size() == 8) held = live;
                end
                if (rd_e) build(fq.pop_front());
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic push(bit [7:0] d);
        fq.push_back(d);
        refresh();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (lvl_q.size() == 0 && fq.size() == 0) break;
        end
        step(6);
    endtask

    task automatic fmt(bit [1:0] l, bit pe, bit po, bit sl);
        char_len = l; parity_en = pe; parity_odd = po; stop_long = sl;
    endtask

    // Watchdog
    initial begin
        #1000000;
        miscompares++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        step(4);
        @(negedge clk);
        check("R1", "tx_out", tx_out, 1'b1);
        check("R1", "loop_rx", loop_rx, 1'b1);
        check("R1", "busy", busy, 1'b0);
        check("R1", "fifo_rd", fifo_rd, 1'b0);
        check("R1", "shift_empty", shift_empty, 1'b0);
        step(1);
        rst_n = 1'b1;
        model_on = 1'b1;

        req = "R2"; fmt(2'b11, 0, 0, 0); push(8'hA5); wait_idle();
        req = "R3"; fmt(2'b00, 0, 0, 0); push(8'hF6); wait_idle();
        fmt(2'b01, 0, 0, 0); push(8'hCB); wait_idle();
        fmt(2'b10, 0, 0, 0); push(8'hD4); wait_idle();
        req = "R4"; fmt(2'b11, 1, 0, 0); push(8'h37); wait_idle();
        fmt(2'b11, 1, 1, 0); push(8'h37); wait_idle();
        fmt(2'b00, 1, 1, 0); push(8'hE1); wait_idle();
        req = "R5"; fmt(2'b00, 0, 0, 1); push(8'h15); wait_idle();
        fmt(2'b10, 1, 0, 1); push(8'h6C); wait_idle();
        tick_div = 1;
        fmt(2'b00, 1, 0, 1); push(8'h0A); push(8'h1F); wait_idle();
        req = "R6"; fmt(2'b11, 0, 0, 0); push(8'h01); push(8'h80); push(8'hFF); wait_idle();
        tick_div = 3;
        push(8'h5A); push(8'hC3); wait_idle();
        req = "R7"; afe = 1'b0; cts_n = 1'b1; push(8'h99); push(8'h66); wait_idle();
        req = "R8"; afe = 1'b1; cts_n = 1'b1; push(8'h3C); step(400);
        cts_n = 1'b0; wait_idle();
        req = "R9"; push(8'hAA); push(8'h55); step(200);
        cts_n = 1'b1; step(700); cts_n = 1'b0; wait_idle();
        push(8'h12); push(8'h34); push(8'h56);
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            if (fq.size() == 1 && lvl_q.size() > 0 && lvl_q.size() < 5) break;
        end
        #2; cts_n = 1'b1; step(900); cts_n = 1'b0; wait_idle();
        afe = 1'b0;
        req = "R10"; push(8'hF0); step(150); break_en = 1'b1; step(60); break_en = 1'b0; wait_idle();
        break_en = 1'b1; step(30); break_en = 1'b0; step(5);
        req = "R11"; loopback = 1'b1; push(8'h4D); step(200);
        break_en = 1'b1; step(40); break_en = 1'b0; wait_idle();
        loopback = 1'b0;
        req = "R12"; fmt(2'b01, 1, 1, 1); push(8'h2B); wait_idle();
        step(10);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule